// File: doc/BRIEF.md
# Nibble Bus Address Decoder with Bank Switch

This block sits between a processor's nibble-wide memory bus and the memories behind it. It takes a 20-bit nibble address and picks the target for each access. The target is one of five: a read-only program store, system RAM, two plug-in port memories, or a 64-nibble register window. The choice follows the top address nibble, the configured base and match mask of each mapped window, and a fixed priority. The decoder raises one chip select, drives the local address that the selected memory needs, and gates the write enables. It also returns the read nibble of the chosen memory.

Two small 4 K areas hold control space instead of memory, and a read there always returns the constant nibble 7. One of them is a bank area. Here the address of a read, not any data, loads a bank register. That register supplies the upper bits of the second port's local address, so a large card can be paged through a 64 K window. Configuration values are static inputs. They are set by surrounding logic outside this block.

The decode result is a target class with seven named values: NONE, IO, CTL, RAM, P1, P2 and ROM. It is chosen by a priority chain in that order: register window, control areas, RAM, port 1, port 2, program store, then NONE. The only registered state is the bank register. It has one transition: a load on a qualifying read in the bank area, and a hold on every other cycle.

Top module: `nbd_decoder`

## Requirements
- R1: An access at 0x00100..0x0013F with `cfg_io_base` equal to 0x00100 selects the register window (`io_cs`), with `local_addr` = address − 0x00100; a write there also raises `io_we`.
- R2: With `cfg_io_base` set to any other value, an access in 0x00100..0x0013F selects nothing, writes nothing and reads 0.
- R3: RAM is hit when `(addr ^ cfg_ram_base) & cfg_ram_mask` is zero. For example, mask 0xFC000 opens 0x4000 nibbles, 0xFE000 opens 0x2000, and 0xF0000 or 0xC0000 open the whole masked range. `local_addr` = address − base, and a write raises `ram_we`.
- R4: When windows overlap, RAM wins over port 1 and port 1 wins over port 2; at most one chip select is active.
- R5: A port 1 hit (same mask rule, base not 0x7E000) gives `local_addr` = (address − base) & `cfg_p1_size_mask`; `p1_we` rises only on a write with `cfg_p1_is_ram` set.
- R6: A port 2 hit gives `local_addr` = ((bank << 18) + (address − base)) & `cfg_p2_size_mask`; `p2_we` needs a write with `cfg_p2_is_ram` set.
- R7: A read of 0x7F000 with `cfg_bank_ctl_en` set clears the bank register; the new value is used from the next cycle.
- R8: A read at 0x7F040..0x7F07F with `cfg_bank_ctl_en` set loads bank = (address − 0x7F040) / 2 for the next cycle. Writes, other bank-area reads and all other accesses leave the bank unchanged.
- R9: The control areas are the bank area (0x7F000..0x7FFFF, when enabled) and the port area (0x7E000..0x7EFFF, when either port base equals 0x7E000). Reads there return 0x7 with no chip select. Writes there are discarded.
- R10: Any other address is routed to the program store when it is below 0x80000, giving `rom_cs` on reads and `local_addr` = address. Above that, the read returns 0 and nothing is selected. The program store is never written.
- R11: After reset the bank register is 0, and with `acc_valid` low no chip select or write enable is active.
- R12: `rd_nibble` carries the read data of the selected target; `local_addr` is 0 when no memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 20 | Nibble address |
| cfg_io_base | input | 20 | Register window base (active only at 0x00100) |
| cfg_ram_base | input | 20 | RAM window base |
| cfg_ram_mask | input | 20 | RAM window match mask |
| cfg_p1_base | input | 20 | Port 1 window base |
| cfg_p1_mask | input | 20 | Port 1 window match mask |
| cfg_p2_base | input | 20 | Port 2 window base |
| cfg_p2_mask | input | 20 | Port 2 window match mask |
| cfg_bank_ctl_en | input | 1 | Bank control area enabled |
| cfg_p1_is_ram | input | 1 | Port 1 is writable |
| cfg_p2_is_ram | input | 1 | Port 2 is writable |
| cfg_p1_size_mask | input | 23 | Port 1 local address mask |
| cfg_p2_size_mask | input | 23 | Port 2 local address mask |
| rom_rdata | input | 4 | Program store read nibble |
| ram_rdata | input | 4 | RAM read nibble |
| p1_rdata | input | 4 | Port 1 read nibble |
| p2_rdata | input | 4 | Port 2 read nibble |
| io_rdata | input | 4 | Register window read nibble |
| rom_cs | output | 1 | Program store select (reads only) |
| ram_cs | output | 1 | RAM select |
| p1_cs | output | 1 | Port 1 select |
| p2_cs | output | 1 | Port 2 select |
| io_cs | output | 1 | Register window select |
| ram_we | output | 1 | RAM write enable |
| p1_we | output | 1 | Port 1 write enable |
| p2_we | output | 1 | Port 2 write enable |
| io_we | output | 1 | Register window write enable |
| local_addr | output | 23 | Translated address for the selected target |
| rd_nibble | output | 4 | Read data returned to the bus |

## Verification
The properties assume that configuration inputs are quasi-static. They also assume that every window base is aligned to its own match mask, so that the offset from the base equals the masked-off low bits. The bank properties further assume that `acc_addr` and `acc_write` are stable for the whole cycle in which `acc_valid` is high. The stimulus meets all of this by loading one of four fixed, aligned configurations before each burst and by driving each access for exactly one cycle. Addresses are biased toward the register window, the bank window, both control areas and the window edges, so the priority and bank-load paths are hit often.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
    localparam int ADDR_W = 20;
    localparam int NIB_W  = 4;

    // register window
    localparam logic [ADDR_W-1:0] IO_WIN_BASE = 20'h00100;
    localparam int                IO_WIN_SPAN = 64;

    // control areas are 4K aligned; only the bits above AREA_LSB are compared
    localparam int                AREA_LSB       = 12;
    localparam logic [ADDR_W-1:0] BANK_AREA_BASE = 20'h7F000;
    localparam logic [ADDR_W-1:0] PORT_AREA_BASE = 20'h7E000;

    // read addresses that load the bank register, two per bank value
    localparam logic [ADDR_W-1:0] BANK_WIN_BASE = 20'h7F040;
    localparam int                BANK_WIN_SPAN = 64;
    localparam int                BANK_W        = $clog2(BANK_WIN_SPAN / 2);

    localparam logic [NIB_W-1:0]  CTL_NIBBLE = 4'h7;

    // mapped windows sharing the base/mask match rule
    localparam int N_WIN   = 3;
    localparam int WIN_RAM = 0;
    localparam int WIN_P1  = 1;
    localparam int WIN_P2  = 2;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_IO,
        TGT_CTL,
        TGT_RAM,
        TGT_P1,
        TGT_P2,
        TGT_ROM
    } target_e;
endpackage

// File: rtl/nbd_window_match.sv
module nbd_window_match #(
    parameter int AW = 20
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    output logic          hit,
    output logic [AW-1:0] offset
);
    // masked compare: the mask picks which address bits must equal the base
    assign hit    = ((addr ^ base) & mask) == '0;
    assign offset = addr - base;
endmodule

// File: rtl/nbd_bank_reg.sv
module nbd_bank_reg
    import nbd_pkg::*;
#(
    parameter int BW = BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [BW-1:0]     bank_q
);
    logic [BW-1:0] bank_d;
    logic          in_win;

    assign in_win = (addr >= BANK_WIN_BASE) &&
                    (addr <  BANK_WIN_BASE + ADDR_W'(BANK_WIN_SPAN));

    // next value: clear, load from address, or hold
    always_comb begin
        bank_d = bank_q;
        if (bank_rd) begin
            if (addr == BANK_AREA_BASE) begin
                bank_d = '0;
            end else if (in_win) begin
                bank_d = BW'((addr - BANK_WIN_BASE) >> 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end
endmodule

// File: rtl/nbd_route.sv
module nbd_route
    import nbd_pkg::*;
#(
    parameter int          BANK_SHIFT  = 18,
    parameter int          BW          = BANK_W,
    parameter int          LOC_W       = BANK_SHIFT + BW,
    parameter int unsigned ROM_NIBBLES = 32'h80000
) (
    input  logic                           acc_valid,
    input  logic                           acc_write,
    input  logic [ADDR_W-1:0]              acc_addr,
    input  logic [ADDR_W-1:0]              cfg_io_base,
    input  logic                           cfg_bank_ctl_en,
    input  logic [ADDR_W-1:0]              cfg_p1_base,
    input  logic [ADDR_W-1:0]              cfg_p2_base,
    input  logic                           cfg_p1_is_ram,
    input  logic                           cfg_p2_is_ram,
    input  logic [LOC_W-1:0]               cfg_p1_size_mask,
    input  logic [LOC_W-1:0]               cfg_p2_size_mask,
    input  logic [N_WIN-1:0]               win_hit,
    input  logic [N_WIN-1:0][ADDR_W-1:0]   win_off,
    input  logic [BW-1:0]                  bank_q,
    input  logic [NIB_W-1:0]               rom_rdata,
    input  logic [NIB_W-1:0]               ram_rdata,
    input  logic [NIB_W-1:0]               p1_rdata,
    input  logic [NIB_W-1:0]               p2_rdata,
    input  logic [NIB_W-1:0]               io_rdata,
    output logic                           rom_cs,
    output logic                           ram_cs,
    output logic                           p1_cs,
    output logic                           p2_cs,
    output logic                           io_cs,
    output logic                           ram_we,
    output logic                           p1_we,
    output logic                           p2_we,
    output logic                           io_we,
    output logic [LOC_W-1:0]               local_addr,
    output logic [NIB_W-1:0]               rd_nibble,
    output logic                           bank_rd
);
    target_e    target;
    logic       io_win;
    logic       io_on;
    logic       bank_area;
    logic       port_area;
    logic       p1_ctl;
    logic       p2_ctl;
    logic       in_rom;
    logic [LOC_W-1:0] p2_paged;

    assign io_win    = (acc_addr >= IO_WIN_BASE) &&
                       (acc_addr <  IO_WIN_BASE + ADDR_W'(IO_WIN_SPAN));
    assign io_on     = (cfg_io_base == IO_WIN_BASE);
    assign bank_area = cfg_bank_ctl_en &&
                       (acc_addr[ADDR_W-1:AREA_LSB] == BANK_AREA_BASE[ADDR_W-1:AREA_LSB]);
    assign p1_ctl    = (cfg_p1_base == PORT_AREA_BASE);
    assign p2_ctl    = (cfg_p2_base == PORT_AREA_BASE);
    assign port_area = (p1_ctl || p2_ctl) &&
                       (acc_addr[ADDR_W-1:AREA_LSB] == PORT_AREA_BASE[ADDR_W-1:AREA_LSB]);
    assign in_rom    = 32'(acc_addr) < ROM_NIBBLES;

    // port 2 paging: bank bits sit above the in-window offset
    assign p2_paged  = {bank_q, {BANK_SHIFT{1'b0}}} + LOC_W'(win_off[WIN_P2]);

    // priority chain: window, control areas, RAM, port 1, port 2, store
    always_comb begin
        if (io_win) begin
            target = io_on ? TGT_IO : TGT_NONE;
        end else if (bank_area || port_area) begin
            target = TGT_CTL;
        end else if (win_hit[WIN_RAM]) begin
            target = TGT_RAM;
        end else if (win_hit[WIN_P1] && !p1_ctl) begin
            target = TGT_P1;
        end else if (win_hit[WIN_P2] && !p2_ctl) begin
            target = TGT_P2;
        end else if (in_rom) begin
            target = TGT_ROM;
        end else begin
            target = TGT_NONE;
        end
    end

    // reads in the bank area drive the bank register update
    assign bank_rd = acc_valid && !acc_write && bank_area;

    // per-target outputs
    always_comb begin
        rom_cs     = 1'b0;
        ram_cs     = 1'b0;
        p1_cs      = 1'b0;
        p2_cs      = 1'b0;
        io_cs      = 1'b0;
        ram_we     = 1'b0;
        p1_we      = 1'b0;
        p2_we      = 1'b0;
        io_we      = 1'b0;
        local_addr = '0;
        rd_nibble  = '0;
        unique case (target)
            TGT_IO: begin
                io_cs      = acc_valid;
                io_we      = acc_valid && acc_write;
                local_addr = LOC_W'(acc_addr - IO_WIN_BASE);
                rd_nibble  = io_rdata;
            end
            TGT_CTL: begin
                rd_nibble  = CTL_NIBBLE;
            end
            TGT_RAM: begin
                ram_cs     = acc_valid;
                ram_we     = acc_valid && acc_write;
                local_addr = LOC_W'(win_off[WIN_RAM]);
                rd_nibble  = ram_rdata;
            end
            TGT_P1: begin
                p1_cs      = acc_valid;
                p1_we      = acc_valid && acc_write && cfg_p1_is_ram;
                local_addr = LOC_W'(win_off[WIN_P1]) & cfg_p1_size_mask;
                rd_nibble  = p1_rdata;
            end
            TGT_P2: begin
                p2_cs      = acc_valid;
                p2_we      = acc_valid && acc_write && cfg_p2_is_ram;
                local_addr = p2_paged & cfg_p2_size_mask;
                rd_nibble  = p2_rdata;
            end
            TGT_ROM: begin
                rom_cs     = acc_valid && !acc_write;
                local_addr = LOC_W'(acc_addr);
                rd_nibble  = rom_rdata;
            end
            TGT_NONE: begin
                rd_nibble  = '0;
            end
            default: begin
                rd_nibble  = '0;
            end
        endcase
    end
endmodule

// File: rtl/nbd_decoder.sv
module nbd_decoder
    import nbd_pkg::*;
#(
    parameter int          BANK_SHIFT  = 18,
    parameter int unsigned ROM_NIBBLES = 32'h80000,
    localparam int         LOC_W       = BANK_SHIFT + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [19:0]       acc_addr,
    input  logic [19:0]       cfg_io_base,
    input  logic [19:0]       cfg_ram_base,
    input  logic [19:0]       cfg_ram_mask,
    input  logic [19:0]       cfg_p1_base,
    input  logic [19:0]       cfg_p1_mask,
    input  logic [19:0]       cfg_p2_base,
    input  logic [19:0]       cfg_p2_mask,
    input  logic              cfg_bank_ctl_en,
    input  logic              cfg_p1_is_ram,
    input  logic              cfg_p2_is_ram,
    input  logic [LOC_W-1:0]  cfg_p1_size_mask,
    input  logic [LOC_W-1:0]  cfg_p2_size_mask,
    input  logic [3:0]        rom_rdata,
    input  logic [3:0]        ram_rdata,
    input  logic [3:0]        p1_rdata,
    input  logic [3:0]        p2_rdata,
    input  logic [3:0]        io_rdata,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic              p1_cs,
    output logic              p2_cs,
    output logic              io_cs,
    output logic              ram_we,
    output logic              p1_we,
    output logic              p2_we,
    output logic              io_we,
    output logic [LOC_W-1:0]  local_addr,
    output logic [3:0]        rd_nibble
);
    logic [N_WIN-1:0][ADDR_W-1:0] win_base;
    logic [N_WIN-1:0][ADDR_W-1:0] win_mask;
    logic [N_WIN-1:0][ADDR_W-1:0] win_off;
    logic [N_WIN-1:0]             win_hit;
    logic [BANK_W-1:0]            bank_q;
    logic                         bank_rd;

    assign win_base[WIN_RAM] = cfg_ram_base;
    assign win_mask[WIN_RAM] = cfg_ram_mask;
    assign win_base[WIN_P1]  = cfg_p1_base;
    assign win_mask[WIN_P1]  = cfg_p1_mask;
    assign win_base[WIN_P2]  = cfg_p2_base;
    assign win_mask[WIN_P2]  = cfg_p2_mask;

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        nbd_window_match #(.AW(ADDR_W)) u_match (
            .addr   (acc_addr),
            .base   (win_base[g]),
            .mask   (win_mask[g]),
            .hit    (win_hit[g]),
            .offset (win_off[g])
        );
    end

    nbd_bank_reg #(.BW(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_rd (bank_rd),
        .addr    (acc_addr),
        .bank_q  (bank_q)
    );

    nbd_route #(
        .BANK_SHIFT  (BANK_SHIFT),
        .BW          (BANK_W),
        .LOC_W       (LOC_W),
        .ROM_NIBBLES (ROM_NIBBLES)
    ) u_route (
        .acc_valid        (acc_valid),
        .acc_write        (acc_write),
        .acc_addr         (acc_addr),
        .cfg_io_base      (cfg_io_base),
        .cfg_bank_ctl_en  (cfg_bank_ctl_en),
        .cfg_p1_base      (cfg_p1_base),
        .cfg_p2_base      (cfg_p2_base),
        .cfg_p1_is_ram    (cfg_p1_is_ram),
        .cfg_p2_is_ram    (cfg_p2_is_ram),
        .cfg_p1_size_mask (cfg_p1_size_mask),
        .cfg_p2_size_mask (cfg_p2_size_mask),
        .win_hit          (win_hit),
        .win_off          (win_off),
        .bank_q           (bank_q),
        .rom_rdata        (rom_rdata),
        .ram_rdata        (ram_rdata),
        .p1_rdata         (p1_rdata),
        .p2_rdata         (p2_rdata),
        .io_rdata         (io_rdata),
        .rom_cs           (rom_cs),
        .ram_cs           (ram_cs),
        .p1_cs            (p1_cs),
        .p2_cs            (p2_cs),
        .io_cs            (io_cs),
        .ram_we           (ram_we),
        .p1_we            (p1_we),
        .p2_we            (p2_we),
        .io_we            (io_we),
        .local_addr       (local_addr),
        .rd_nibble        (rd_nibble),
        .bank_rd          (bank_rd)
    );
endmodule

// File: rtl/nbd_decoder_chk.sv
module nbd_decoder_chk
    import nbd_pkg::*;
#(
    parameter int BW = BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [ADDR_W-1:0] cfg_io_base,
    input logic              cfg_bank_ctl_en,
    input logic              cfg_p1_is_ram,
    input logic              cfg_p2_is_ram,
    input logic              rom_cs,
    input logic              ram_cs,
    input logic              p1_cs,
    input logic              p2_cs,
    input logic              io_cs,
    input logic              ram_we,
    input logic              p1_we,
    input logic              p2_we,
    input logic              io_we,
    input logic [NIB_W-1:0]  rd_nibble,
    input logic [BW-1:0]     bank_q
);
    logic [4:0] cs_vec;
    logic [3:0] we_vec;
    logic       io_zone;
    logic       bank_zone;
    logic       bank_rd_zero;
    logic       bank_rd_load;

    assign cs_vec       = {rom_cs, ram_cs, p1_cs, p2_cs, io_cs};
    assign we_vec       = {ram_we, p1_we, p2_we, io_we};
    assign io_zone      = acc_addr >= 20'h00100 && acc_addr <= 20'h0013F;
    assign bank_zone    = cfg_bank_ctl_en && acc_addr[19:12] == 8'h7F;
    assign bank_rd_zero = acc_valid && !acc_write && cfg_bank_ctl_en && acc_addr == 20'h7F000;
    assign bank_rd_load = acc_valid && !acc_write && cfg_bank_ctl_en &&
                          acc_addr >= 20'h7F040 && acc_addr <= 20'h7F07F;

    AST_IO_ON_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        io_cs |-> cfg_io_base == 20'h00100);                                    // R1
    AST_IO_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && io_zone && cfg_io_base != 20'h00100)
        |-> (cs_vec == '0 && we_vec == '0 && (acc_write || rd_nibble == '0)));  // R2
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_vec));                                                      // R4
    AST_P1_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        p1_we |-> (cfg_p1_is_ram && p1_cs && acc_write));                       // R5
    AST_P2_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        p2_we |-> (cfg_p2_is_ram && p2_cs && acc_write));                       // R6
    AST_BANK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd_zero |=> bank_q == '0);                                         // R7
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd_load |=> bank_q == BW'(($past(acc_addr) - 20'h7F040) >> 1));    // R8
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write && bank_zone) |=> $stable(bank_q));           // R8
    AST_CTL_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && bank_zone)
        |-> (rd_nibble == 4'h7 && cs_vec == '0));                               // R9
    AST_CTL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && bank_zone) |-> we_vec == '0);                // R9
    AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> !acc_write);                                                 // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (cs_vec == '0 && we_vec == '0));                         // R11
endmodule

bind nbd_decoder nbd_decoder_chk #(.BW(BANK_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_write       (acc_write),
    .acc_addr        (acc_addr),
    .cfg_io_base     (cfg_io_base),
    .cfg_bank_ctl_en (cfg_bank_ctl_en),
    .cfg_p1_is_ram   (cfg_p1_is_ram),
    .cfg_p2_is_ram   (cfg_p2_is_ram),
    .rom_cs          (rom_cs),
    .ram_cs          (ram_cs),
    .p1_cs           (p1_cs),
    .p2_cs           (p2_cs),
    .io_cs           (io_cs),
    .ram_we          (ram_we),
    .p1_we           (p1_we),
    .p2_we           (p2_we),
    .io_we           (io_we),
    .rd_nibble       (rd_nibble),
    .bank_q          (bank_q)
);

// File: tb/test_nbd_decoder.sv
`timescale 1ns/1ps
module test_nbd_decoder;
    localparam int LW = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [19:0]   acc_addr = '0;
    logic [19:0]   io_base, ram_base, ram_mask, p1_base, p1_mask, p2_base, p2_mask;
    logic          bank_en, p1_ram, p2_ram;
    logic [LW-1:0] p1_sz, p2_sz;
    logic [3:0]    rom_rd, ram_rd, p1_rd, p2_rd, io_rd;
    logic          rom_cs, ram_cs, p1_cs, p2_cs, io_cs, ram_we, p1_we, p2_we, io_we;
    logic [LW-1:0] local_addr;
    logic [3:0]    rd_nibble;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [4:0]    bank_m = '0;
    logic [8:0]    e_sel;
    logic [LW-1:0] e_loc;
    logic [3:0]    e_rd;
    string         e_tag;

    always #5 clk = ~clk;

    nbd_decoder i_nbd_decoder (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .cfg_io_base(io_base), .cfg_ram_base(ram_base),
        .cfg_ram_mask(ram_mask), .cfg_p1_base(p1_base), .cfg_p1_mask(p1_mask),
        .cfg_p2_base(p2_base), .cfg_p2_mask(p2_mask), .cfg_bank_ctl_en(bank_en),
        .cfg_p1_is_ram(p1_ram), .cfg_p2_is_ram(p2_ram), .cfg_p1_size_mask(p1_sz),
        .cfg_p2_size_mask(p2_sz), .rom_rdata(rom_rd), .ram_rdata(ram_rd),
        .p1_rdata(p1_rd), .p2_rdata(p2_rd), .io_rdata(io_rd), .rom_cs(rom_cs),
        .ram_cs(ram_cs), .p1_cs(p1_cs), .p2_cs(p2_cs), .io_cs(io_cs),
        .ram_we(ram_we), .p1_we(p1_we), .p2_we(p2_we), .io_we(io_we),
        .local_addr(local_addr), .rd_nibble(rd_nibble)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [8:0] sel_now();
        return {rom_cs, ram_cs, p1_cs, p2_cs, io_cs, ram_we, p1_we, p2_we, io_we};
    endfunction

    // expected outputs computed from the requirements
    function automatic void model(input logic [19:0] a, input logic wr);
        logic ram_h, p1_h, p2_h, p1c, p2c;
        ram_h = ((a ^ ram_base) & ram_mask) == 20'h0;
        p1_h  = ((a ^ p1_base) & p1_mask) == 20'h0;
        p2_h  = ((a ^ p2_base) & p2_mask) == 20'h0;
        p1c   = p1_base == 20'h7E000;
        p2c   = p2_base == 20'h7E000;
        e_sel = '0;
        e_loc = '0;
        e_rd  = 4'h0;
        e_tag = "R10";
        if (a >= 20'h00100 && a < 20'h00140) begin
            if (io_base == 20'h00100) begin
                e_tag = "R1"; e_sel[4] = 1'b1; e_sel[0] = wr;
                e_loc = LW'(a - 20'h00100); e_rd = io_rd;
            end else begin
                e_tag = "R2";
            end
        end else if ((bank_en && a[19:12] == 8'h7F) || ((p1c || p2c) && a[19:12] == 8'h7E)) begin
            e_tag = "R9"; e_rd = 4'h7;
        end else if (ram_h) begin
            e_tag = (p1_h || p2_h) ? "R4" : "R3";
            e_sel[7] = 1'b1; e_sel[3] = wr;
            e_loc = LW'(a - ram_base); e_rd = ram_rd;
        end else if (p1_h && !p1c) begin
            e_tag = p2_h ? "R4" : "R5";
            e_sel[6] = 1'b1; e_sel[2] = wr && p1_ram;
            e_loc = LW'(a - p1_base) & p1_sz; e_rd = p1_rd;
        end else if (p2_h && !p2c) begin
            e_tag = "R6";
            e_sel[5] = 1'b1; e_sel[1] = wr && p2_ram;
            e_loc = ({bank_m, 18'h0} + LW'(a - p2_base)) & p2_sz; e_rd = p2_rd;
        end else if (a < 20'h80000) begin
            e_sel[8] = !wr; e_loc = LW'(a); e_rd = rom_rd;
        end
    endfunction

    task automatic access(input logic [19:0] a, input logic wr);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a;
        rom_rd = 4'($urandom); ram_rd = 4'($urandom); p1_rd = 4'($urandom);
        p2_rd = 4'($urandom); io_rd = 4'($urandom);
        #2;
        model(a, wr);
        chk(e_tag, "selects", 32'(sel_now()), 32'(e_sel));
        chk(e_tag, "local_addr", 32'(local_addr), 32'(e_loc));
        if (!wr) chk((e_sel[8:4] != 0) ? "R12" : e_tag, "rd_nibble", 32'(rd_nibble), 32'(e_rd));
        if (!wr && bank_en && a[19:12] == 8'h7F) begin
            if (a == 20'h7F000) bank_m = '0;
            else if (a >= 20'h7F040 && a < 20'h7F080) bank_m = 5'((a - 20'h7F040) >> 1);
        end
    endtask

    task automatic set_cfg(input int s);
        case (s)
            0: begin
                io_base = 20'h00100; ram_base = 20'h80000; ram_mask = 20'hC0000;
                p1_base = 20'hC0000; p1_mask = 20'hC0000; p1_ram = 1'b1;
                p2_base = 20'h80000; p2_mask = 20'hC0000; p2_ram = 1'b1;
                bank_en = 1'b1; p1_sz = 23'h03FFFF; p2_sz = 23'h7FFFFF;
            end
            1: begin
                io_base = 20'h00100; ram_base = 20'h80000; ram_mask = 20'hFC000;
                p1_base = 20'hA0000; p1_mask = 20'hF0000; p1_ram = 1'b1;
                p2_base = 20'hB0000; p2_mask = 20'hF0000; p2_ram = 1'b1;
                bank_en = 1'b1; p1_sz = 23'h00FFFF; p2_sz = 23'h7FFFFF;
            end
            2: begin
                io_base = 20'h00000; ram_base = 20'hC0000; ram_mask = 20'hFE000;
                p1_base = 20'h7E000; p1_mask = 20'hFF000; p1_ram = 1'b0;
                p2_base = 20'hC0000; p2_mask = 20'hC0000; p2_ram = 1'b0;
                bank_en = 1'b0; p1_sz = 23'h000FFF; p2_sz = 23'h0FFFFF;
            end
            default: begin
                io_base = 20'h00100; ram_base = 20'h40000; ram_mask = 20'hF0000;
                p1_base = 20'h80000; p1_mask = 20'hC0000; p1_ram = 1'b0;
                p2_base = 20'hC0000; p2_mask = 20'hC0000; p2_ram = 1'b1;
                bank_en = 1'b1; p1_sz = 23'h01FFFF; p2_sz = 23'h1FFFFF;
            end
        endcase
    endtask

    function automatic logic [19:0] pick_addr();
        case ($urandom % 8)
            0: return 20'h00100 + 20'($urandom % 64);
            1: return 20'h7F040 + 20'($urandom % 64);
            2: return 20'h7F000;
            3: return {8'h7F, 12'($urandom)};
            4: return {8'h7E, 12'($urandom)};
            default: return 20'($urandom);
        endcase
    endfunction

    initial begin
        #(100_000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        set_cfg(1);
        rom_rd = 4'h1; ram_rd = 4'h2; p1_rd = 4'h3; p2_rd = 4'h4; io_rd = 4'h5;
        repeat (3) @(posedge clk);
        #2;
        chk("R11", "selects in reset", 32'(sel_now()), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R11", "selects idle", 32'(sel_now()), 32'h0);

        // bank starts at 0 after reset
        access(20'hB0005, 1'b0);
        chk("R11", "p2 page 0", 32'(local_addr), 32'h000005);
        // load bank 3, use it one cycle later
        access(20'h7F046, 1'b0);
        access(20'hB0005, 1'b0);
        chk("R8", "p2 page 3", 32'(local_addr), 32'h0C0005);
        // bank-area read outside the load window and a write leave it alone
        access(20'h7F010, 1'b0);
        access(20'h7F07E, 1'b1);
        access(20'hB0005, 1'b0);
        chk("R8", "p2 page kept", 32'(local_addr), 32'h0C0005);
        // top of the load window
        access(20'h7F07F, 1'b0);
        access(20'hB0000, 1'b0);
        chk("R8", "p2 page 31", 32'(local_addr), 32'h7C0000);
        // clear through the area base
        access(20'h7F000, 1'b0);
        chk("R9", "ctl nibble", 32'(rd_nibble), 32'h7);
        access(20'hB0000, 1'b0);
        chk("R7", "p2 page cleared", 32'(local_addr), 32'h0);
        // register window edges and RAM size edges
        access(20'h0013F, 1'b1);
        chk("R1", "io local top", 32'(local_addr), 32'h3F);
        access(20'h00140, 1'b0);
        access(20'h83FFF, 1'b1);
        chk("R3", "ram top we", 32'(ram_we), 32'h1);
        access(20'h84000, 1'b1);
        chk("R3", "beyond ram", 32'(ram_we), 32'h0);
        // register window switched off, unmapped high address
        set_cfg(2);
        access(20'h00120, 1'b0);
        chk("R2", "io off read", 32'(rd_nibble), 32'h0);
        access(20'h7E123, 1'b1);
        access(20'h90000, 1'b0);
        chk("R10", "unmapped read", 32'(rd_nibble), 32'h0);
        // overlap priority
        set_cfg(0);
        access(20'h81234, 1'b1);
        chk("R4", "ram beats p2", 32'(sel_now()), 32'h088);
        set_cfg(3);
        access(20'h80010, 1'b1);
        chk("R5", "p1 rom write", 32'(p1_we), 32'h0);

        // random bursts over every configuration
        for (int i = 0; i < 3000; i++) begin
            if (i % 250 == 0) set_cfg(int'($urandom % 4));
            access(pick_addr(), ($urandom % 4) == 0);
        end

        @(negedge clk);
        acc_valid = 1'b0;
        #2;
        chk("R11", "selects idle end", 32'(sel_now()), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule